// File: doc/BRIEF.md
# Timer Compare Waveform Unit

This block is an 8-bit timer with a single compare channel that generates a waveform on one output pin. On every clock the counter either runs freely from zero to its full-scale value or restarts early at the compare value. The counter value is compared with a compare register. A two-bit output-action code and a three-bit waveform-mode field decide what the output flip-flop does on a compare hit and on the last count of a period (TOP).

The same action code means different things in the two families of modes. In the non-PWM modes each code picks a single action on a compare hit. In fast PWM the output is set or cleared at TOP and driven the opposite way on the hit. The action code also decides whether the waveform takes over the pin, and a separate direction bit then gates the pin driver. The compare register is double-buffered in fast PWM and follows its input directly in the other modes.

Top module: `tmr_wave_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the compare register and `wave_q` become 0 at that edge. With all control inputs at 0 the pin is then neither overridden nor driven.
- R2: `pin_ovr` is 1 whenever `out_code` is nonzero, with one exception: fast PWM with `out_code`=01 and `wave_mode[2]`=0. `pin_oe` is 1 only when `pin_ovr` and `dir_en` are both 1.
- R3: `wave_mode[1:0]` selects the mode: 00 is free-running, 10 is clear-on-match, 11 is fast PWM, and 01 behaves as free-running. TOP is 0xFF in free-running mode and in fast PWM with `wave_mode[2]`=0. TOP is the compare register in clear-on-match mode and in fast PWM with `wave_mode[2]`=1. The counter counts up by one each cycle and goes to 0 on the cycle after it equals TOP.
- R4: In the non-PWM modes, a cycle in which the counter equals the compare register has this effect on `wave_q` at the next edge: code 01 toggles it, 10 clears it and 11 sets it.
- R5: In fast PWM, code 10 sets `wave_q` at TOP and clears it on a compare hit, giving 65 high cycles out of 256 for a compare value of 0x40 and TOP 0xFF. Code 11 sets it on a hit and clears it at TOP, giving 191 high cycles out of 256.
- R6: In fast PWM, code 01 leaves `wave_q` and the pin untouched when `wave_mode[2]`=0. It toggles `wave_q` on a compare hit when `wave_mode[2]`=1.
- R7: In fast PWM with `out_code[1]`=1, when the compare register equals TOP the hit is ignored and only the TOP action applies. With TOP 0xFF and compare 0xFF, code 10 therefore keeps the output high in all 256 cycles and code 11 keeps it low in all 256.
- R8: In fast PWM, the compare register takes `cmp_val` only at the edge that ends a cycle in which the counter equals TOP. In the other modes it takes `cmp_val` at every edge.
- R9: With `out_code`=00 the output flip-flop holds its value in every mode, and `pin_ovr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_code | input | 2 | Output action code |
| wave_mode | input | 3 | Waveform mode; bit 2 selects the compare register as TOP in fast PWM |
| cmp_val | input | 8 | Compare value |
| dir_en | input | 1 | Pin direction bit; 1 allows the pin driver |
| wave_q | output | 1 | Output flip-flop, the value placed on the pin |
| pin_ovr | output | 1 | Waveform takes over the pin function |
| pin_oe | output | 1 | Pin driver enable |

## Verification
The assertions check the following on every cycle:
- the counter step and its wrap at TOP;
- the buffering of the compare register;
- the gating of the pin driver;
- the hold of the output under code 00;
- the TOP actions and the compare-hit actions in fast PWM and in the non-PWM modes.

Some behaviours only show over whole periods, so only the bench scenarios can show them. These are the duty-cycle counts, the toggle period in clear-on-match mode, the fully high or fully low output when the compare value equals TOP, and a compare value changed in mid-period taking effect only in the next period. The bench's full sweep of mode, code and compare value against a cycle model covers all combinations at their boundaries.

// File: rtl/tmr_wave_pkg.sv
// Package tmr_wave_pkg
// Shared types of the timer compare waveform unit.
// Assumes: the low two bits of the waveform mode select the mode family.
package tmr_wave_pkg;

    typedef enum logic [1:0] {
        WG_FREE   = 2'b00,
        WG_RSVD   = 2'b01,
        WG_CLRHIT = 2'b10,
        WG_FAST   = 2'b11
    } wg_base_e;

    typedef enum logic [1:0] {
        OC_OFF    = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_LOW    = 2'b10,
        OC_HIGH   = 2'b11
    } oc_code_e;

    // Action the output flip-flop takes at the next edge
    typedef struct packed {
        logic set;
        logic clr;
        logic tgl;
    } oc_act_t;

endpackage

// File: rtl/tmr_count.sv
// Module tmr_count
// Counter, compare register and TOP selection.
// The counter goes up by one per cycle and wraps to zero after TOP.
// In fast PWM the compare register loads only at TOP; in the other
// modes it loads at every edge.
// Assumes: synchronous active-low reset; W >= 2.
module tmr_count #(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  tmr_wave_pkg::wg_base_e  base,
    input  logic                    top_sel,
    input  logic [W-1:0]            cmp_val,
    output logic [W-1:0]            cnt,
    output logic [W-1:0]            ocr,
    output logic [W-1:0]            top_v,
    output logic                    top_hit,
    output logic                    cmp_hit,
    output logic                    ocr_is_top
);
    import tmr_wave_pkg::*;

    localparam logic [W-1:0] FULL = {W{1'b1}};

    logic is_fast;
    logic top_from_ocr;
    logic ocr_load;

    // Decode the mode family and decide where TOP comes from
    always_comb begin
        is_fast      = (base == WG_FAST);
        top_from_ocr = (base == WG_CLRHIT) || (is_fast && top_sel);
        top_v        = top_from_ocr ? ocr : FULL;
        top_hit      = (cnt == top_v);
        cmp_hit      = (cnt == ocr);
        ocr_is_top   = (ocr == top_v);
        ocr_load     = !is_fast || top_hit;
    end

    // Counter: step up, return to zero after TOP
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (top_hit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Compare register: direct in non-PWM, buffered to TOP in fast PWM
    always_ff @(posedge clk) begin
        if (!rst_n)
            ocr <= '0;
        else if (ocr_load)
            ocr <= cmp_val;
    end

endmodule

// File: rtl/tmr_mode_dec.sv
// Module tmr_mode_dec
// Turns the action code, the mode and the hit flags into one action
// for the output flip-flop, and decides whether the pin is taken over.
// Assumes: hits are those of the current cycle; the action takes
// effect at the next edge.
module tmr_mode_dec (
    input  tmr_wave_pkg::wg_base_e  base,
    input  logic                    top_sel,
    input  logic [1:0]              code,
    input  logic                    top_hit,
    input  logic                    cmp_hit,
    input  logic                    ocr_is_top,
    output tmr_wave_pkg::oc_act_t   act,
    output logic                    connected
);
    import tmr_wave_pkg::*;

    logic is_fast;
    logic hit_live;

    // Select the action from the code table of the active mode family
    always_comb begin
        is_fast   = (base == WG_FAST);
        // a hit is masked when the compare register equals TOP in fast PWM
        hit_live  = cmp_hit && !(is_fast && code[1] && ocr_is_top);
        act       = '0;
        connected = 1'b0;
        if (!is_fast) begin
            connected = (code != OC_OFF);
            unique case (oc_code_e'(code))
                OC_OFF:    act = '0;
                OC_TOGGLE: act.tgl = cmp_hit;
                OC_LOW:    act.clr = cmp_hit;
                OC_HIGH:   act.set = cmp_hit;
            endcase
        end else begin
            unique case (oc_code_e'(code))
                OC_OFF: begin
                    connected = 1'b0;
                end
                OC_TOGGLE: begin
                    connected = top_sel;
                    act.tgl   = top_sel && cmp_hit;
                end
                OC_LOW: begin
                    connected = 1'b1;
                    act.set   = top_hit;
                    act.clr   = hit_live && !top_hit;
                end
                OC_HIGH: begin
                    connected = 1'b1;
                    act.clr   = top_hit;
                    act.set   = hit_live && !top_hit;
                end
            endcase
        end
    end

endmodule

// File: rtl/tmr_wave_out.sv
// Module tmr_wave_out
// Output flip-flop and pin override.
// The flip-flop applies at most one of set, clear or toggle per edge.
// The pin driver is enabled only when the waveform owns the pin and
// the direction bit is set.
// Assumes: at most one action bit is high in any cycle.
module tmr_wave_out (
    input  logic                   clk,
    input  logic                   rst_n,
    input  tmr_wave_pkg::oc_act_t  act,
    input  logic                   connected,
    input  logic                   dir_en,
    output logic                   wave_q,
    output logic                   pin_ovr,
    output logic                   pin_oe
);

    // Output flip-flop: apply the action chosen for this cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave_q <= 1'b0;
        else if (act.set)
            wave_q <= 1'b1;
        else if (act.clr)
            wave_q <= 1'b0;
        else if (act.tgl)
            wave_q <= !wave_q;
    end

    // Pin ownership and driver gating
    always_comb begin
        pin_ovr = connected;
        pin_oe  = connected && dir_en;
    end

endmodule

// File: rtl/tmr_wave_unit.sv
// Module tmr_wave_unit
// Timer with one compare channel that drives a waveform pin.
// It connects the counter, the mode decoder and the output stage.
// Assumes: all control inputs are synchronous to clk.
module tmr_wave_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       out_code,
    input  logic [2:0]       wave_mode,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             dir_en,
    output logic             wave_q,
    output logic             pin_ovr,
    output logic             pin_oe
);
    import tmr_wave_pkg::*;

    wg_base_e         base;
    logic             top_sel;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ocr_q;
    logic [CNT_W-1:0] top_v;
    logic             top_hit;
    logic             cmp_hit;
    logic             ocr_is_top;
    oc_act_t          act;
    logic             connected;

    // Split the waveform mode into the mode family and the TOP select
    always_comb begin
        base    = wg_base_e'(wave_mode[1:0]);
        top_sel = wave_mode[2];
    end

    tmr_count #(.W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .base       (base),
        .top_sel    (top_sel),
        .cmp_val    (cmp_val),
        .cnt        (cnt_q),
        .ocr        (ocr_q),
        .top_v      (top_v),
        .top_hit    (top_hit),
        .cmp_hit    (cmp_hit),
        .ocr_is_top (ocr_is_top)
    );

    tmr_mode_dec u_dec (
        .base       (base),
        .top_sel    (top_sel),
        .code       (out_code),
        .top_hit    (top_hit),
        .cmp_hit    (cmp_hit),
        .ocr_is_top (ocr_is_top),
        .act        (act),
        .connected  (connected)
    );

    tmr_wave_out u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .connected (connected),
        .dir_en    (dir_en),
        .wave_q    (wave_q),
        .pin_ovr   (pin_ovr),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/tmr_wave_chk.sv
// Module tmr_wave_chk
// Assertion checker bound into tmr_wave_unit.
// It watches the ports plus the counter, the compare register and TOP.
// Assumes: synchronous active-low reset.
module tmr_wave_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   out_code,
    input logic [2:0]   wave_mode,
    input logic [W-1:0] cmp_val,
    input logic         dir_en,
    input logic         wave_q,
    input logic         pin_ovr,
    input logic         pin_oe,
    input logic [W-1:0] cnt,
    input logic [W-1:0] ocr,
    input logic [W-1:0] top
);
    logic fast;
    assign fast = (wave_mode[1:0] == 2'b11);

    // R1: reset clears counter and output
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (wave_q == 1'b0 && cnt == '0));

    // R2: no driver without the direction bit or pin ownership
    p_oe_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_en || !pin_ovr) |-> !pin_oe);

    // R3: step below TOP
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != top) |=> (cnt == W'($past(cnt) + 1'b1)));

    // R3: wrap after TOP
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == top) |=> (cnt == '0));

    // R4: set on hit in non-PWM modes
    p_nonpwm_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && out_code == 2'b11 && cnt == ocr) |=> wave_q);

    // R4: clear on hit in non-PWM modes
    p_nonpwm_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && out_code == 2'b10 && cnt == ocr) |=> !wave_q);

    // R5: non-inverting sets at TOP
    p_fast_top_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && out_code == 2'b10 && cnt == top) |=> wave_q);

    // R5: inverting clears at TOP
    p_fast_top_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && out_code == 2'b11 && cnt == top) |=> !wave_q);

    // R7: non-inverting hit below TOP clears
    p_fast_hit_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && out_code == 2'b10 && cnt == ocr && ocr != top) |=> !wave_q);

    // R8: buffered compare register holds between TOPs
    p_ocr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && cnt != top) |=> $stable(ocr));

    // R8: direct load in non-PWM modes
    p_ocr_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast) |=> (ocr == $past(cmp_val)));

    // R9: code 00 holds the output flip-flop
    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_code == 2'b00) |=> $stable(wave_q));

endmodule

bind tmr_wave_unit tmr_wave_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_code  (out_code),
    .wave_mode (wave_mode),
    .cmp_val   (cmp_val),
    .dir_en    (dir_en),
    .wave_q    (wave_q),
    .pin_ovr   (pin_ovr),
    .pin_oe    (pin_oe),
    .cnt       (cnt_q),
    .ocr       (ocr_q),
    .top       (top_v)
);

// File: tb/tmr_wave_unit_test.sv
// Bench tmr_wave_unit_test
// Directed scenarios plus a sweep against a cycle model built from
// the requirements.
module tmr_wave_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] out_code = 2'b00;
    logic [2:0] wave_mode = 3'b000;
    logic [7:0] cmp_val = 8'h00;
    logic       dir_en = 1'b0;
    logic       wave_q;
    logic       pin_ovr;
    logic       pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_wave_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_code  (out_code),
        .wave_mode (wave_mode),
        .cmp_val   (cmp_val),
        .dir_en    (dir_en),
        .wave_q    (wave_q),
        .pin_ovr   (pin_ovr),
        .pin_oe    (pin_oe)
    );

    // Cycle model state
    logic [7:0] m_cnt, m_ocr;
    logic       m_q;

    // Cycle model from R1, R3..R9
    always @(posedge clk) begin
        logic       fast, hit, at_top, masked;
        logic [7:0] tp;
        if (!rst_n) begin
            m_cnt <= 8'h00; m_ocr <= 8'h00; m_q <= 1'b0;
        end else begin
            fast   = (wave_mode[1:0] == 2'b11);
            tp     = ((wave_mode[1:0] == 2'b10) || (fast && wave_mode[2])) ? m_ocr : 8'hFF;
            at_top = (m_cnt == tp);
            hit    = (m_cnt == m_ocr);
            masked = fast && out_code[1] && (m_ocr == tp);
            m_cnt <= at_top ? 8'h00 : m_cnt + 8'd1;
            if (!fast || at_top) m_ocr <= cmp_val;
            if (!fast) begin
                case (out_code)
                    2'b01: if (hit) m_q <= ~m_q;
                    2'b10: if (hit) m_q <= 1'b0;
                    2'b11: if (hit) m_q <= 1'b1;
                    default: ;
                endcase
            end else begin
                case (out_code)
                    2'b01: if (wave_mode[2] && hit) m_q <= ~m_q;
                    2'b10: if (at_top) m_q <= 1'b1; else if (hit && !masked) m_q <= 1'b0;
                    2'b11: if (at_top) m_q <= 1'b0; else if (hit && !masked) m_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic exp_ovr();
        if (out_code == 2'b00) return 1'b0;
        if (wave_mode[1:0] == 2'b11 && out_code == 2'b01 && !wave_mode[2]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Run n cycles comparing ports with the model at each falling edge
    task automatic run_model(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req, wave_q, m_q);
            check("R2 ovr", pin_ovr, exp_ovr());
            check("R2 oe", pin_oe, exp_ovr() && dir_en);
        end
    endtask

    // Count high samples over n falling edges
    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wave_q) hi++;
        end
    endtask

    task automatic t_reset();
        out_code = 2'b00; wave_mode = 3'b000; cmp_val = 8'h00; dir_en = 1'b0;
        do_reset();
        check("R1 wave_q", wave_q, 0);
        check("R1 pin_ovr", pin_ovr, 0);
        check("R1 pin_oe", pin_oe, 0);
    endtask

    task automatic t_gate();
        @(negedge clk) begin out_code = 2'b10; wave_mode = 3'b000; dir_en = 1'b0; end
        #1 check("R2 ovr code10", pin_ovr, 1);
        check("R2 oe dir0", pin_oe, 0);
        dir_en = 1'b1;
        #1 check("R2 oe dir1", pin_oe, 1);
        wave_mode = 3'b011; out_code = 2'b01;
        #1 check("R2 fast code01 sel0 ovr", pin_ovr, 0);
        check("R2 fast code01 sel0 oe", pin_oe, 0);
        wave_mode = 3'b111;
        #1 check("R2 fast code01 sel1 ovr", pin_ovr, 1);
    endtask

    task automatic t_ctc_toggle();
        int tog;
        logic prev;
        out_code = 2'b01; wave_mode = 3'b010; cmp_val = 8'd3; dir_en = 1'b1;
        do_reset();
        repeat (20) @(negedge clk);
        prev = wave_q; tog = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (wave_q != prev) tog++;
            prev = wave_q;
        end
        check("R3 R4 clear-on-match toggles per 40 cycles", tog, 10);
    endtask

    task automatic t_duty();
        int hi;
        out_code = 2'b10; wave_mode = 3'b011; cmp_val = 8'h40; dir_en = 1'b1;
        do_reset();
        repeat (300) @(negedge clk);
        count_high(256, hi);
        check("R5 non-inverting high count", hi, 65);
        out_code = 2'b11;
        repeat (300) @(negedge clk);
        count_high(256, hi);
        check("R5 inverting high count", hi, 191);
    endtask

    task automatic t_top_equal();
        int hi;
        out_code = 2'b10; wave_mode = 3'b011; cmp_val = 8'hFF; dir_en = 1'b1;
        do_reset();
        repeat (300) @(negedge clk);
        count_high(256, hi);
        check("R7 code10 compare at TOP", hi, 256);
        out_code = 2'b11;
        repeat (300) @(negedge clk);
        count_high(256, hi);
        check("R7 code11 compare at TOP", hi, 0);
    endtask

    task automatic t_fast_toggle();
        out_code = 2'b01; wave_mode = 3'b011; cmp_val = 8'h10; dir_en = 1'b1;
        do_reset();
        run_model(300, "R6 fast code01 sel0");
        check("R6 sel0 output untouched", wave_q, 0);
        wave_mode = 3'b111; cmp_val = 8'h07;
        run_model(300, "R6 fast code01 sel1");
    endtask

    task automatic t_midchange();
        out_code = 2'b10; wave_mode = 3'b011; cmp_val = 8'h40; dir_en = 1'b1;
        do_reset();
        run_model(300, "R8 buffered");
        @(negedge clk) cmp_val = 8'hC0;
        run_model(600, "R8 mid-period change");
        out_code = 2'b11; wave_mode = 3'b000; cmp_val = 8'h20;
        run_model(300, "R8 direct");
        @(negedge clk) cmp_val = 8'h90;
        run_model(300, "R8 direct change");
    endtask

    task automatic t_hold();
        out_code = 2'b11; wave_mode = 3'b000; cmp_val = 8'h05; dir_en = 1'b1;
        do_reset();
        repeat (10) @(negedge clk);
        check("R4 set on hit", wave_q, 1);
        out_code = 2'b00;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            check("R9 hold under code 00", wave_q, 1);
            check("R9 no override", pin_ovr, 0);
        end
    endtask

    task automatic t_sweep();
        logic [7:0] cv [3];
        cv[0] = 8'h00; cv[1] = 8'h03; cv[2] = 8'hFF;
        for (int wm = 0; wm < 8; wm++)
            for (int oc = 0; oc < 4; oc++)
                for (int k = 0; k < 3; k++) begin
                    wave_mode = 3'(wm); out_code = 2'(oc);
                    cmp_val = cv[k]; dir_en = 1'(k);
                    do_reset();
                    run_model(300, "R3 R4 R5 R6 R7 R9 sweep");
                end
    endtask

    initial begin
        t_reset();
        t_gate();
        t_ctc_toggle();
        t_duty();
        t_top_equal();
        t_fast_toggle();
        t_midchange();
        t_hold();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule